// File: doc/BRIEF.md
# Flash Erase-Block Selector

This block guards erasure of an on-chip flash array split into ten blocks of unequal size. Software picks the one block it wants to erase by setting a single bit across two byte-wide select registers. Any address presented on the check port is then mapped to its block. The block raises an erase-permit flag only when that address lies in the chosen block.

The select registers empty themselves whenever erasing would be unsafe: during either standby mode, when the external write-enable pin is low, and when the software write-enable bit is clear. The block also holds a program-setup flag that can only be raised while both enables are high. While flash is disabled, the select registers read as zero and ignore writes.

Top module: `flash_erase_guard`

## Requirements
- R1: After reset, both select registers read 0x00 and the setup flag reads 0.
- R2: At each clock edge where hw_standby or sw_standby is high, or wen_pin or sw_wen is low, both select registers are set to 0x00, and any write in that cycle is lost.
- R3: Register offsets on bus_addr: 0 is the upper select register, 1 is the lower select register, 2 is the setup flag in bit 0, and 3 reads 0x00. Lower bit k selects block k (0..7). Upper bit 0 selects block 8 and upper bit 1 selects block 9. Upper bits 7:2 are never stored and read 0.
- R4: A write that would leave more than one of the ten select bits set is rejected, and both registers keep their contents.
- R5: While flash_en is low, reads of offsets 0 and 1 return 0x00 and writes to them have no effect.
- R6: blk_idx and blk_valid map chk_addr as follows: 0x000000–0x000FFF to blocks 0–3 (1 KB each), 0x001000–0x007FFF to 4, 0x008000–0x00BFFF to 5, 0x00C000–0x00DFFF to 6, 0x00E000–0x00FFFF to 7, 0x010000–0x017FFF to 8, 0x018000–0x01FFFF to 9. For addresses at or above 0x020000, blk_valid is 0.
- R7: erase_ok is high exactly when blk_valid is high and the select bit of blk_idx is set. It is combinational from chk_addr and the register contents.
- R8: A write of 1 to the setup flag takes effect only while wen_pin and sw_wen are both 1. The flag is cleared at any edge where either of them is 0. Writing 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wen_pin | input | 1 | External write-enable pin level |
| sw_wen | input | 1 | Software write-enable bit |
| hw_standby | input | 1 | Hardware standby active |
| sw_standby | input | 1 | Software standby active |
| flash_en | input | 1 | On-chip flash enabled |
| chk_addr | input | ADDR_W | Flash address to classify |
| erase_ok | output | 1 | Address may be erased |
| blk_idx | output | 4 | Block containing chk_addr |
| blk_valid | output | 1 | chk_addr lies inside the block map |

## Verification
Register writes and clear conditions are captured at the next rising edge. Read data, the block decode and erase_ok are combinational, so they are correct one edge after a stimulus. The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It then returns the write strobe and clear inputs to idle at the following falling edge. It samples outputs one time unit after changing bus_addr or chk_addr, well clear of any rising edge. This way each result is read in the half-cycle after the edge that produced it.

// File: rtl/flash_erase_guard.sv
module flash_erase_guard #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              wen_pin,
  input  logic              sw_wen,
  input  logic              hw_standby,
  input  logic              sw_standby,
  input  logic              flash_en,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              erase_ok,
  output logic [3:0]        blk_idx,
  output logic              blk_valid
);
  localparam int NBLK   = 10;
  localparam int MAP_LG = 17;

  logic [1:0] sel_hi;
  logic [7:0] sel_lo;
  logic       setup_q;
  logic [NBLK-1:0] sel_all, cand;
  logic wr_hi, wr_lo, cand_ok, clr_sel, both_en;

  assign sel_all = {sel_hi, sel_lo};
  assign both_en = wen_pin && sw_wen;
  assign clr_sel = hw_standby || sw_standby || !both_en;
  assign wr_hi   = bus_wr && flash_en && bus_addr == 2'd0;
  assign wr_lo   = bus_wr && flash_en && bus_addr == 2'd1;
  assign cand    = wr_hi ? {bus_wdata[1:0], sel_lo} : {sel_hi, bus_wdata};
  assign cand_ok = $countones(cand) <= 1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_hi <= '0;
      sel_lo <= '0;
    end else if (clr_sel) begin
      sel_hi <= '0;
      sel_lo <= '0;
    end else if (cand_ok) begin
      if (wr_hi) sel_hi <= bus_wdata[1:0];
      if (wr_lo) sel_lo <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              setup_q <= 1'b0;
    else if (!both_en)                       setup_q <= 1'b0;
    else if (bus_wr && bus_addr == 2'd2)     setup_q <= bus_wdata[0];

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = flash_en ? {6'b0, sel_hi} : 8'h00;
      2'd1:    bus_rdata = flash_en ? sel_lo : 8'h00;
      2'd2:    bus_rdata = {7'b0, setup_q};
      default: bus_rdata = 8'h00;
    endcase

  always_comb begin
    blk_valid = (chk_addr >> MAP_LG) == '0;
    if (chk_addr[16])           blk_idx = chk_addr[15] ? 4'd9 : 4'd8;
    else if (chk_addr[15])      blk_idx = !chk_addr[14] ? 4'd5 : (chk_addr[13] ? 4'd7 : 4'd6);
    else if (|chk_addr[14:12])  blk_idx = 4'd4;
    else                        blk_idx = {2'b0, chk_addr[11:10]};
  end

  assign erase_ok = blk_valid && sel_all[blk_idx];

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_all) <= 1);
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sel |=> sel_all == '0);
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_en && !clr_sel) |=> $stable(sel_all));
  a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_en && bus_addr[1] == 1'b0) |-> bus_rdata == 8'h00);
  a_r7_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |-> !erase_ok);
  a_r8_setup_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !both_en |=> !setup_q);
endmodule

// File: tb/flash_erase_guard_tb_top.sv
module flash_erase_guard_tb_top;
  localparam int PERIOD = 10;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic wen_pin = 1, sw_wen = 1, hw_standby = 0, sw_standby = 0, flash_en = 1;
  logic [AW-1:0] chk_addr = 0;
  logic erase_ok, blk_valid;
  logic [3:0] blk_idx;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  flash_erase_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wen_pin(wen_pin),
    .sw_wen(sw_wen), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .flash_en(flash_en), .chk_addr(chk_addr), .erase_ok(erase_ok),
    .blk_idx(blk_idx), .blk_valid(blk_valid));

  function automatic int exp_blk(int a);
    if (a < 4 * 1024) return a / 1024;
    if (a < 'h8000)   return 4;
    if (a < 'hC000)   return 5;
    if (a < 'hE000)   return 6;
    if (a < 'h10000)  return 7;
    if (a < 'h18000)  return 8;
    if (a < 'h20000)  return 9;
    return -1;
  endfunction

  function automatic int blk_first(int b);
    case (b)
      0, 1, 2, 3: return b * 1024;
      4: return 'h1000;  5: return 'h8000;  6: return 'hC000;
      7: return 'hE000;  8: return 'h10000; default: return 'h18000;
    endcase
  endfunction

  function automatic int blk_last(int b);
    return (b == 9) ? 'h1FFFF : blk_first(b + 1) - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(string req, logic [1:0] a, int exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse_clear(int which);
    @(negedge clk);
    case (which)
      0: hw_standby = 1; 1: sw_standby = 1; 2: wen_pin = 0; default: sw_wen = 0;
    endcase
    @(negedge clk);
    hw_standby = 0; sw_standby = 0; wen_pin = 1; sw_wen = 1;
  endtask

  task automatic pick(int b);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    if (b >= 8) wr(2'd0, 8'(1 << (b - 8)));
    else        wr(2'd1, 8'(1 << b));
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 3); rst_n = 1;
    @(negedge clk);
    rd("R1", 2'd0, 0); rd("R1", 2'd1, 0); rd("R1", 2'd2, 0); rd("R3", 2'd3, 0);

    // R6: first and last address of every block, plus beyond the map
    for (int b = 0; b < 10; b++) begin
      chk_addr = AW'(blk_first(b)); #1;
      chk("R6", blk_idx, exp_blk(blk_first(b))); chk("R6", blk_valid, 1);
      chk_addr = AW'(blk_last(b)); #1;
      chk("R6", blk_idx, exp_blk(blk_last(b))); chk("R6", blk_valid, 1);
    end
    chk_addr = AW'('h20000); #1; chk("R6", blk_valid, 0);
    chk_addr = '1;           #1; chk("R6", blk_valid, 0);

    // R7 and R3: each selection against every boundary address
    for (int s = 0; s < 10; s++) begin
      pick(s);
      rd("R3", 2'd0, s >= 8 ? (1 << (s - 8)) : 0);
      rd("R3", 2'd1, s < 8 ? (1 << s) : 0);
      for (int b = 0; b < 10; b++) begin
        chk_addr = AW'(blk_first(b)); #1; chk("R7", erase_ok, int'(b == s));
        chk_addr = AW'(blk_last(b));  #1; chk("R7", erase_ok, int'(b == s));
      end
      chk_addr = AW'('h20000 + blk_first(s)); #1; chk("R7", erase_ok, 0);
    end

    // R3: upper bits 7:2 not stored
    pick(9); wr(2'd0, 8'hFE); rd("R3", 2'd0, 8'h02);

    // R4: one-hot rejection
    pick(0);
    wr(2'd0, 8'h01); rd("R4", 2'd0, 0); rd("R4", 2'd1, 8'h01);
    wr(2'd1, 8'h03); rd("R4", 2'd1, 8'h01);
    wr(2'd1, 8'hFF); rd("R4", 2'd1, 8'h01);
    wr(2'd0, 8'hFC); rd("R4", 2'd0, 0); rd("R4", 2'd1, 8'h01);
    wr(2'd1, 8'h04); rd("R4", 2'd1, 8'h04);

    // R2: each clear condition
    for (int c = 0; c < 4; c++) begin
      pick(c == 3 ? 8 : 3);
      pulse_clear(c);
      rd("R2", 2'd0, 0); rd("R2", 2'd1, 0);
      chk_addr = AW'('h0C00); #1; chk("R2", erase_ok, 0);
    end
    // R2: write during a clear cycle is lost
    @(negedge clk); sw_standby = 1; bus_addr = 2'd1; bus_wdata = 8'h20; bus_wr = 1;
    @(negedge clk); sw_standby = 0; bus_wr = 0;
    rd("R2", 2'd1, 0);

    // R5: disabled flash
    pick(4);
    @(negedge clk); flash_en = 0;
    rd("R5", 2'd0, 0); rd("R5", 2'd1, 0);
    wr(2'd1, 8'h00); wr(2'd0, 8'h01);
    @(negedge clk); flash_en = 1;
    rd("R5", 2'd1, 8'h10); rd("R5", 2'd0, 0);

    // R8: setup flag
    wr(2'd2, 8'h01); rd("R8", 2'd2, 1);
    wr(2'd2, 8'h00); rd("R8", 2'd2, 0);
    wr(2'd2, 8'h01); pulse_clear(3); rd("R8", 2'd2, 0);
    wr(2'd2, 8'h01); pulse_clear(2); rd("R8", 2'd2, 0);
    @(negedge clk); wen_pin = 0; bus_addr = 2'd2; bus_wdata = 8'h01; bus_wr = 1;
    @(negedge clk); bus_wr = 0; wen_pin = 1;
    rd("R8", 2'd2, 0);
    wr(2'd2, 8'h01); pulse_clear(0); rd("R8", 2'd2, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule